// File: doc/BRIEF.md
# Video Interrupt Pending and Acknowledge Controller

This block sits beside a display controller and turns its two interrupt sources into a 3-bit priority level for a CPU. A horizontal event (from a line counter outside the block) marks the horizontal source pending at once. A vblank-start event raises the vblank status flag at once, but it marks the vertical source pending only after a fixed number of CPU cycles. Those cycles are counted on a CPU clock-enable input. Two enable bits, which come from control registers held elsewhere, decide whether each pending source may drive the level.

The output level follows from the pending bits and the enables through combinational logic. Writing an enable therefore raises or drops the level in the same cycle. The CPU's interrupt acknowledge strobe clears one pending bit. The block chooses that bit from its own pending bits and enables, and it does not use the level the CPU reports. Disabling a source leaves its pending bit in place.

Top module: `vid_irq_ctrl`

## Requirements
- R1: After reset, pending_flags is 0x00, irq_level is 0 and vblank_flag is 0.
- R2: A vblank_start pulse sets vblank_flag at the next clock edge. A vblank_end pulse clears it. If both arrive together, the start wins.
- R3: After vblank_start, the vertical pending bit (pending_flags bit 5) is set at the clock edge that samples the VINT_DELAY-th cycle with cpu_ce high. It is not set earlier.
- R4: A vblank_start that arrives while the delay is still running restarts the count from zero. If it arrives in the same cycle as the final count, the vertical pending bit is not set from the old count.
- R5: irq_level is 6 while bit 5 is pending and vint_en is high. Otherwise it is 4 while bit 4 is pending and hint_en is high. Otherwise it is 0. pending_flags bit 4 is the horizontal pending bit, and all other bits read 0.
- R6: The level depends on the enables with no register in the path, so enabling a source that is already pending raises irq_level in the same cycle. Pending bits stay set while their enable is low.
- R7: On an acknowledge while the vertical source is pending and enabled, only bit 5 is cleared. The level then becomes 4 if the horizontal source is pending and enabled, and 0 otherwise.
- R8: On an acknowledge while the vertical source does not qualify but the horizontal source is pending and enabled, bit 4 is cleared and the level becomes 0.
- R9: An acknowledge while no source is both pending and enabled changes no pending bit. The ack_level value never affects which bit is cleared.
- R10: When a set and an acknowledge-clear hit the same pending bit in one cycle, the bit ends up set.
- R11: A hint_event pulse sets pending bit 4 at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_ce | input | 1 | One-cycle enable for each CPU clock cycle |
| vblank_start | input | 1 | Pulse at the start of vertical blanking |
| vblank_end | input | 1 | Pulse at the end of vertical blanking |
| hint_event | input | 1 | Pulse from the horizontal interrupt counter |
| vint_en | input | 1 | Vertical interrupt enable bit from the control register |
| hint_en | input | 1 | Horizontal interrupt enable bit from the control register |
| ack | input | 1 | CPU interrupt acknowledge strobe |
| ack_level | input | 3 | Level reported with the acknowledge (ignored) |
| irq_level | output | 3 | Encoded interrupt priority level (0, 4 or 6) |
| pending_flags | output | 8 | Pending readback: bit 5 vertical, bit 4 horizontal |
| vblank_flag | output | 1 | Vblank status flag |

## Verification
The bench builds the block with VINT_DELAY set to 6 instead of 112. This keeps the exact boundary within a few directed pulses: five CPU-enable cycles leave the vertical bit clear and the sixth sets it. With the short delay, a restart in the middle of the count and a final count that lands on the same edge as an acknowledge are cheap to set up. The bench holds cpu_ce low between pulses, so the delay is counted only in CPU-enable cycles and not in clocks.

// File: rtl/vid_irq_pkg.sv
package vid_irq_pkg;
  localparam int unsigned LVL_W      = 3;
  localparam int unsigned FLAGS_W    = 8;
  localparam int unsigned VPEND_BIT  = 5;
  localparam int unsigned HPEND_BIT  = 4;
  localparam logic [LVL_W-1:0] LVL_NONE = 3'd0;
  localparam logic [LVL_W-1:0] LVL_HORZ = 3'd4;
  localparam logic [LVL_W-1:0] LVL_VERT = 3'd6;

  typedef struct packed {
    logic vert;
    logic horz;
  } pend_t;
endpackage

// File: rtl/vid_irq_vtimer.sv
module vid_irq_vtimer #(
  parameter int unsigned DELAY = 112
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_ce,
  input  logic start,
  output logic fire
);
  localparam int unsigned CW = $clog2(DELAY + 1);
  localparam logic [CW-1:0] LOAD = CW'(DELAY);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  logic          last;

  assign last = busy_q && cpu_ce && (cnt_q == ONE);
  assign fire = last && !start;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (start) begin
      cnt_d  = LOAD;
      busy_d = 1'b1;
    end else if (busy_q && cpu_ce) begin
      if (cnt_q == ONE) begin
        busy_d = 1'b0;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end
endmodule

// File: rtl/vid_irq_pend.sv
module vid_irq_pend
  import vid_irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  vset,
  input  logic  hset,
  input  logic  vint_en,
  input  logic  hint_en,
  input  logic  ack,
  output pend_t pend
);
  pend_t pend_q, pend_d;

  assign pend = pend_q;

  always_comb begin
    pend_d = pend_q;
    if (ack) begin
      if (pend_q.vert && vint_en) begin
        pend_d.vert = 1'b0;
      end else if (pend_q.horz && hint_en) begin
        pend_d.horz = 1'b0;
      end
    end
    if (vset) pend_d.vert = 1'b1;
    if (hset) pend_d.horz = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/vid_irq_enc.sv
module vid_irq_enc
  import vid_irq_pkg::*;
(
  input  pend_t             pend,
  input  logic              vint_en,
  input  logic              hint_en,
  output logic [LVL_W-1:0]  level,
  output logic [FLAGS_W-1:0] flags
);
  always_comb begin
    if (pend.vert && vint_en) begin
      level = LVL_VERT;
    end else if (pend.horz && hint_en) begin
      level = LVL_HORZ;
    end else begin
      level = LVL_NONE;
    end
  end

  always_comb begin
    flags            = '0;
    flags[VPEND_BIT] = pend.vert;
    flags[HPEND_BIT] = pend.horz;
  end
endmodule

// File: rtl/vid_irq_ctrl.sv
module vid_irq_ctrl
  import vid_irq_pkg::*;
#(
  parameter int unsigned VINT_DELAY = 112
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_ce,
  input  logic        vblank_start,
  input  logic        vblank_end,
  input  logic        hint_event,
  input  logic        vint_en,
  input  logic        hint_en,
  input  logic        ack,
  input  logic [2:0]  ack_level,
  output logic [2:0]  irq_level,
  output logic [7:0]  pending_flags,
  output logic        vblank_flag
);
  logic  vfire;
  pend_t pend;
  logic  vbl_q, vbl_d;
  logic  unused_lvl;

  // the reported level plays no part in the acknowledge decision
  assign unused_lvl = ^ack_level;

  vid_irq_vtimer #(.DELAY(VINT_DELAY)) u_vtimer (
    .clk    (clk),
    .rst_n  (rst_n),
    .cpu_ce (cpu_ce),
    .start  (vblank_start),
    .fire   (vfire)
  );

  vid_irq_pend u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .vset    (vfire),
    .hset    (hint_event),
    .vint_en (vint_en),
    .hint_en (hint_en),
    .ack     (ack),
    .pend    (pend)
  );

  vid_irq_enc u_enc (
    .pend    (pend),
    .vint_en (vint_en),
    .hint_en (hint_en),
    .level   (irq_level),
    .flags   (pending_flags)
  );

  always_comb begin
    vbl_d = vbl_q;
    if (vblank_end)   vbl_d = 1'b0;
    if (vblank_start) vbl_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vbl_q <= 1'b0;
    end else begin
      vbl_q <= vbl_d;
    end
  end

  assign vblank_flag = vbl_q;
endmodule

// File: rtl/vid_irq_ctrl_chk.sv
module vid_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_ce,
  input logic       vblank_start,
  input logic       vblank_end,
  input logic       hint_event,
  input logic       vint_en,
  input logic       hint_en,
  input logic       ack,
  input logic [2:0] irq_level,
  input logic [7:0] pending_flags,
  input logic       vblank_flag
);
  // R2
  vbl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_start |=> vblank_flag);

  // R3
  vset_on_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending_flags[5]) |-> $past(cpu_ce));

  // R5
  vert_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_flags[5] && vint_en) |-> (irq_level == 3'd6));

  // R5
  spare_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_flags[7:6] == 2'b00) && (pending_flags[3:0] == 4'h0));

  // R7
  ack_vert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && pending_flags[5] && vint_en && !cpu_ce) |=> !pending_flags[5]);

  // R8
  ack_horz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !(pending_flags[5] && vint_en) && pending_flags[4] && hint_en
     && !hint_event) |=> !pending_flags[4]);

  // R9
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !(pending_flags[5] && vint_en) && !(pending_flags[4] && hint_en))
    |=> ((pending_flags & $past(pending_flags)) == $past(pending_flags)));

  // R11
  hset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hint_event |=> pending_flags[4]);
endmodule

bind vid_irq_ctrl vid_irq_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_ce        (cpu_ce),
  .vblank_start  (vblank_start),
  .vblank_end    (vblank_end),
  .hint_event    (hint_event),
  .vint_en       (vint_en),
  .hint_en       (hint_en),
  .ack           (ack),
  .irq_level     (irq_level),
  .pending_flags (pending_flags),
  .vblank_flag   (vblank_flag)
);

// File: tb/vid_irq_ctrl_test.sv
module vid_irq_ctrl_test;
  localparam time CLK_PERIOD = 10ns;
  localparam int  DLY = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_ce = 1'b0;
  logic       vblank_start = 1'b0;
  logic       vblank_end = 1'b0;
  logic       hint_event = 1'b0;
  logic       vint_en = 1'b0;
  logic       hint_en = 1'b0;
  logic       ack = 1'b0;
  logic [2:0] ack_level = 3'd0;
  logic [2:0] irq_level;
  logic [7:0] pending_flags;
  logic       vblank_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  vid_irq_ctrl #(.VINT_DELAY(DLY)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_ce(cpu_ce), .vblank_start(vblank_start),
    .vblank_end(vblank_end), .hint_event(hint_event), .vint_en(vint_en),
    .hint_en(hint_en), .ack(ack), .ack_level(ack_level),
    .irq_level(irq_level), .pending_flags(pending_flags),
    .vblank_flag(vblank_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one clock with the currently driven strobes, then release them
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    cpu_ce = 0; vblank_start = 0; vblank_end = 0; hint_event = 0; ack = 0;
  endtask

  task automatic ce_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      cpu_ce = 1;
      step();
    end
  endtask

  task automatic do_ack(input logic [2:0] lvl);
    ack = 1; ack_level = lvl;
    step();
  endtask

  task automatic t_reset();
    chk("R1 flags", pending_flags, 8'h00);
    chk("R1 level", irq_level, 0);
    chk("R1 vblank", vblank_flag, 0);
  endtask

  task automatic t_vblank_flag();
    vblank_start = 1; step();
    chk("R2 set", vblank_flag, 1);
    vblank_end = 1; step();
    chk("R2 clear", vblank_flag, 0);
    vblank_start = 1; vblank_end = 1; step();
    chk("R2 start wins", vblank_flag, 1);
    vblank_end = 1; step();
  endtask

  task automatic t_delay();
    vint_en = 0;
    vblank_start = 1; step();
    ce_pulses(DLY - 1);
    chk("R3 not early", pending_flags, 8'h00);
    ce_pulses(1);
    chk("R3 set on last ce", pending_flags, 8'h20);
    chk("R6 disabled level", irq_level, 0);
    step();
    chk("R6 persists", pending_flags, 8'h20);
    vint_en = 1; #1;
    chk("R6 same-cycle raise", irq_level, 6);
    @(negedge clk);
    do_ack(3'd0);
    chk("R7 vert cleared", pending_flags, 8'h00);
    chk("R7 level", irq_level, 0);
  endtask

  task automatic t_restart();
    vblank_start = 1; step();
    ce_pulses(3);
    vblank_start = 1; step();
    ce_pulses(DLY - 1);
    chk("R4 restarted", pending_flags, 8'h00);
    ce_pulses(1);
    chk("R4 fires after full count", pending_flags, 8'h20);
    do_ack(3'd6);
    vblank_start = 1; step();
    ce_pulses(DLY - 1);
    vblank_start = 1; cpu_ce = 1; step();
    chk("R4 restart on last count", pending_flags, 8'h00);
    ce_pulses(DLY);
    chk("R4 after second count", pending_flags, 8'h20);
    do_ack(3'd6);
  endtask

  task automatic t_hint_prio();
    vint_en = 1; hint_en = 0;
    hint_event = 1; step();
    chk("R11 horz set", pending_flags, 8'h10);
    chk("R5 horz disabled", irq_level, 0);
    hint_en = 1; #1;
    chk("R5 horz level", irq_level, 4);
    @(negedge clk);
    vblank_start = 1; step();
    ce_pulses(DLY);
    chk("R5 both flags", pending_flags, 8'h30);
    chk("R5 vert priority", irq_level, 6);
    do_ack(3'd4);
    chk("R7 only vert cleared", pending_flags, 8'h10);
    chk("R7 level falls to 4", irq_level, 4);
    do_ack(3'd6);
    chk("R8 horz cleared", pending_flags, 8'h00);
    chk("R8 level", irq_level, 0);
  endtask

  task automatic t_ignore();
    hint_en = 0; vint_en = 0;
    hint_event = 1; step();
    do_ack(3'd4);
    chk("R9 horz kept", pending_flags, 8'h10);
    vblank_start = 1; step();
    ce_pulses(DLY);
    do_ack(3'd6);
    chk("R9 both kept", pending_flags, 8'h30);
    vint_en = 1; hint_en = 1;
    do_ack(3'd0);
    do_ack(3'd0);
    chk("R9 drained", pending_flags, 8'h00);
  endtask

  task automatic t_setwins();
    hint_event = 1; step();
    hint_event = 1; ack = 1; step();
    chk("R10 horz set wins", pending_flags, 8'h10);
    do_ack(3'd0);
    vblank_start = 1; step();
    ce_pulses(DLY);
    vblank_start = 1; step();
    ce_pulses(DLY - 1);
    ack = 1; cpu_ce = 1; step();
    chk("R10 vert set wins", pending_flags, 8'h20);
    do_ack(3'd0);
    chk("R10 cleared after", pending_flags, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_vblank_flag();
    t_delay();
    t_restart();
    t_hint_prio();
    t_ignore();
    t_setwins();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule